// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block receives characters from an asynchronous serial line that rests at logic 1 between frames. A falling edge to 0 marks a possible start bit. The block confirms it halfway into the bit, then samples every following bit at its centre using a tick that runs at sixteen times the bit rate. Data bits arrive least significant first and are collected in a private shift register. An optional parity bit follows them, and then a single stop bit ends the frame.

When the stop bit has been sampled, the character is either moved into the visible data register or held back. Four status flags record what happened: data ready, overrun, parity mismatch and bad stop bit. Each kind of error follows its own rule. An overrun keeps the old character and leaves the ready flag set. A parity or stop-bit error still delivers the character. Software consumes a character with a read strobe, which drops the ready flag. It removes error flags with a clear strobe and a per-flag mask. One enable input gates both interrupt outputs: receive-complete and receive-error.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, `rx_data` is 0 and all four flags and both interrupt outputs are 0.
- R2: A low pulse that has ended before the 8th tick after the line fell produces no frame. No flag changes, and a following frame is still received correctly.
- R3: The frame is a 0 start bit, 8 data bits with the least significant bit first, an optional parity bit and a stop bit. A frame with no error, received while `flag_ready` is 0, copies the character to `rx_data` and sets `flag_ready`. `rx_data` changes only when a frame completes.
- R4: A frame that completes while `flag_ready` is 1 sets `flag_overrun` and leaves `rx_data` and `flag_ready` unchanged. The parity and stop-bit flags are not updated by that frame.
- R5: With `par_en`=1, the received parity bit must make the count of ones over the 8 data bits and the parity bit even when `par_odd`=0, or odd when `par_odd`=1. On a mismatch, `flag_parity` is set, the character is still copied to `rx_data`, and `flag_ready` is not set.
- R6: A stop bit sampled as 0 sets `flag_frame`, the character is still copied to `rx_data`, and `flag_ready` is not set.
- R7: With `par_en`=0 the stop bit directly follows the 8th data bit, and `flag_parity` is never set.
- R8: `irq_rx` is 1 exactly when `rie`=1 and `flag_ready`=1. `irq_err` is 1 exactly when `rie`=1 and at least one of the three error flags is 1.
- R9: A one-cycle `rd_en` pulse clears `flag_ready`. Reading each character before the next frame completes allows consecutive frames with no overrun.
- R10: Error flags stay set until a `clr_strobe` cycle whose `clr_mask` has the matching bit set: bit 0 overrun, bit 1 parity, bit 2 stop-bit error. Only the selected flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 = a parity bit follows the data bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rie | input | 1 | Receive interrupt enable |
| rd_en | input | 1 | Read strobe; clears the ready flag |
| clr_strobe | input | 1 | Flag-clear write strobe |
| clr_mask | input | 3 | Flags to clear: bit 0 overrun, bit 1 parity, bit 2 stop-bit error |
| rx_data | output | 8 | Received character register |
| flag_ready | output | 1 | Character waiting |
| flag_overrun | output | 1 | A frame was lost because the previous character was unread |
| flag_parity | output | 1 | Parity mismatch |
| flag_frame | output | 1 | Stop bit sampled as 0 |
| irq_rx | output | 1 | Receive-complete interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The bench builds the block with its default widths: 8 data bits and 16 ticks per bit. It supplies a tick every fourth clock, so one bit lasts 64 clocks. At that rate the bench can hold a stop bit low for only part of its width, or raise the line again before the start check. This exercises the start confirmation and the return to idle after a bad stop bit at their exact sample points. Both parity senses, the no-parity frame length and the three error update rules are each reached within a few frames.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 par_en,
    input  logic                 par_odd,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 ferr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_BITS + 1);
    localparam int HALF  = OVS / 2;

    typedef struct packed {
        rx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] shf;
        logic                 perr;
        logic                 ferr;
        logic                 done;
    } frm_t;

    frm_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick) begin
            case (q.st)
                ST_IDLE: begin
                    if (!line) begin
                        d.st  = ST_START;
                        d.cnt = CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (q.cnt == CNT_W'(HALF - 1)) begin
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.perr = 1'b0;
                        d.st   = line ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (q.cnt == CNT_W'(OVS - 1)) begin
                        d.cnt = '0;
                        d.shf = {line, q.shf[DATA_BITS-1:1]};
                        if (q.idx == IDX_W'(DATA_BITS - 1)) begin
                            d.st = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (q.cnt == CNT_W'(OVS - 1)) begin
                        d.cnt  = '0;
                        d.perr = ((^q.shf) ^ line) != par_odd;
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (q.cnt == CNT_W'(OVS - 1)) begin
                        d.cnt  = '0;
                        d.ferr = !line;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign done = q.done;
    assign data = q.shf;
    assign perr = q.perr;
    assign ferr = q.ferr;
endmodule

// File: rtl/srx_status.sv
module srx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 perr,
    input  logic                 ferr,
    input  logic                 rd_en,
    input  logic                 clr_strobe,
    input  logic [2:0]           clr_mask,
    output logic [DATA_BITS-1:0] rdr,
    output logic                 rdy,
    output logic                 ovr,
    output logic                 per,
    output logic                 fer
);
    typedef struct packed {
        logic [DATA_BITS-1:0] rdr;
        logic                 rdy;
        logic                 ovr;
        logic                 per;
        logic                 fer;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d = q;
        if (rd_en) d.rdy = 1'b0;
        if (clr_strobe) begin
            if (clr_mask[0]) d.ovr = 1'b0;
            if (clr_mask[1]) d.per = 1'b0;
            if (clr_mask[2]) d.fer = 1'b0;
        end
        if (done) begin
            if (q.rdy) begin
                d.ovr = 1'b1;
                d.rdy = 1'b1;
            end else begin
                d.rdr = data;
                if (perr) d.per = 1'b1;
                if (ferr) d.fer = 1'b1;
                d.rdy = !(perr || ferr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdr = q.rdr;
    assign rdy = q.rdy;
    assign ovr = q.ovr;
    assign per = q.per;
    assign fer = q.fer;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 rx_line,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rie,
    input  logic                 rd_en,
    input  logic                 clr_strobe,
    input  logic [2:0]           clr_mask,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 flag_ready,
    output logic                 flag_overrun,
    output logic                 flag_parity,
    output logic                 flag_frame,
    output logic                 irq_rx,
    output logic                 irq_err
);
    logic                 line_s;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_perr;
    logic                 frm_ferr;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    srx_framer #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .line   (line_s),
        .par_en (par_en),
        .par_odd(par_odd),
        .done   (frm_done),
        .data   (frm_data),
        .perr   (frm_perr),
        .ferr   (frm_ferr)
    );

    srx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frm_done),
        .data      (frm_data),
        .perr      (frm_perr),
        .ferr      (frm_ferr),
        .rd_en     (rd_en),
        .clr_strobe(clr_strobe),
        .clr_mask  (clr_mask),
        .rdr       (rx_data),
        .rdy       (flag_ready),
        .ovr       (flag_overrun),
        .per       (flag_parity),
        .fer       (flag_frame)
    );

    assign irq_rx  = rie & flag_ready;
    assign irq_err = rie & (flag_overrun | flag_parity | flag_frame);
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 par_en,
    input logic                 rie,
    input logic                 rd_en,
    input logic                 clr_strobe,
    input logic [2:0]           clr_mask,
    input logic                 frm_done,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 flag_ready,
    input logic                 flag_overrun,
    input logic                 flag_parity,
    input logic                 flag_frame,
    input logic                 irq_rx,
    input logic                 irq_err
);
    AST_DATA_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $past(frm_done)); // R3

    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_overrun) |-> (flag_ready && $past(flag_ready) && $stable(rx_data))); // R4

    AST_NO_PARITY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_parity) |-> par_en); // R7

    AST_ERR_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (rie && (flag_overrun || flag_parity || flag_frame)) |-> irq_err); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !rie |-> (!irq_rx && !irq_err)); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !frm_done) |=> !flag_ready); // R9

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_frame && !(clr_strobe && clr_mask[2])) |=> flag_frame); // R10
endmodule

bind serial_rx_status srx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_en      (par_en),
    .rie         (rie),
    .rd_en       (rd_en),
    .clr_strobe  (clr_strobe),
    .clr_mask    (clr_mask),
    .frm_done    (frm_done),
    .rx_data     (rx_data),
    .flag_ready  (flag_ready),
    .flag_overrun(flag_overrun),
    .flag_parity (flag_parity),
    .flag_frame  (flag_frame),
    .irq_rx      (irq_rx),
    .irq_err     (irq_err)
);

// File: tb/serial_rx_status_test.sv
`timescale 1ns/1ps
module serial_rx_status_test;
    localparam int TICK_DIV = 4;
    localparam int BITCLK   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rie = 1'b0;
    logic       rd_en = 1'b0;
    logic       clr_strobe = 1'b0;
    logic [2:0] clr_mask = 3'b000;
    logic [7:0] rx_data;
    logic       flag_ready, flag_overrun, flag_parity, flag_frame, irq_rx, irq_err;

    int n_chk = 0;
    int n_bad = 0;

    serial_rx_status uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
        .par_en(par_en), .par_odd(par_odd), .rie(rie), .rd_en(rd_en),
        .clr_strobe(clr_strobe), .clr_mask(clr_mask), .rx_data(rx_data),
        .flag_ready(flag_ready), .flag_overrun(flag_overrun),
        .flag_parity(flag_parity), .flag_frame(flag_frame),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int clocks);
        rx_line = v;
        repeat (clocks) @(negedge clk);
    endtask

    // stop_v=0 holds the stop low for 12 of its 16 ticks only
    task automatic send(input logic [7:0] ch, input logic bad_par, input logic stop_v);
        drive_bit(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) drive_bit(ch[i], BITCLK);
        if (par_en) drive_bit((^ch) ^ par_odd ^ bad_par, BITCLK);
        if (stop_v) drive_bit(1'b1, BITCLK);
        else begin
            drive_bit(1'b0, 12 * TICK_DIV);
            drive_bit(1'b1, 4 * TICK_DIV);
        end
        drive_bit(1'b1, 8);
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        clr_strobe = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_strobe = 1'b0;
        clr_mask = 3'b000;
        @(negedge clk);
    endtask

    task automatic flags(input string req, input logic [3:0] exp);
        chk(req, {flag_ready, flag_overrun, flag_parity, flag_frame}, exp);
    endtask

    task automatic t_reset();
        chk("R1 data", rx_data, 8'h00);
        flags("R1 flags", 4'b0000);
        chk("R1 irqs", {irq_rx, irq_err}, 2'b00);
    endtask

    task automatic t_clean();
        rie = 1'b1;
        send(8'hA5, 1'b0, 1'b1);
        chk("R3 data", rx_data, 8'hA5);
        flags("R3 flags", 4'b1000);
        chk("R8 irq_rx on", {irq_rx, irq_err}, 2'b10);
        rie = 1'b0;
        @(negedge clk);
        chk("R8 masked", {irq_rx, irq_err}, 2'b00);
        rie = 1'b1;
        pulse_rd();
        flags("R9 read clears ready", 4'b0000);
    endtask

    task automatic t_back_to_back();
        send(8'h01, 1'b0, 1'b1);
        chk("R9 first", rx_data, 8'h01);
        pulse_rd();
        send(8'h80, 1'b0, 1'b1);
        chk("R9 second", rx_data, 8'h80);
        flags("R9 no overrun", 4'b1000);
        pulse_rd();
    endtask

    task automatic t_overrun();
        send(8'h3C, 1'b0, 1'b1);
        send(8'hC3, 1'b0, 1'b1);
        chk("R4 data kept", rx_data, 8'h3C);
        flags("R4 flags", 4'b1100);
        chk("R8 err irq", irq_err, 1'b1);
        pulse_rd();
        pulse_clr(3'b001);
        flags("R10 clear overrun", 4'b0000);
    endtask

    task automatic t_parity();
        par_en = 1'b1;
        par_odd = 1'b0;
        send(8'h07, 1'b0, 1'b1);
        chk("R5 even ok", rx_data, 8'h07);
        flags("R5 even ok flags", 4'b1000);
        pulse_rd();
        par_odd = 1'b1;
        send(8'h5A, 1'b0, 1'b1);
        flags("R5 odd ok flags", 4'b1000);
        pulse_rd();
        send(8'h96, 1'b1, 1'b1);
        chk("R5 bad parity data", rx_data, 8'h96);
        flags("R5 bad parity flags", 4'b0010);
        chk("R8 parity irq", {irq_rx, irq_err}, 2'b01);
        pulse_clr(3'b001);
        flags("R10 wrong mask keeps parity", 4'b0010);
        pulse_clr(3'b010);
        flags("R10 clear parity", 4'b0000);
        par_en = 1'b0;
        par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send(8'hE1, 1'b0, 1'b0);
        chk("R6 data", rx_data, 8'hE1);
        flags("R6 flags", 4'b0001);
        repeat (2 * BITCLK) @(negedge clk);
        flags("R6 idle after break", 4'b0001);
        send(8'h42, 1'b0, 1'b1);
        chk("R10 sticky data", rx_data, 8'h42);
        flags("R10 frame flag sticky", 4'b1001);
        pulse_clr(3'b011);
        flags("R10 mask selects", 4'b1001);
        pulse_clr(3'b100);
        pulse_rd();
        flags("R10 cleared", 4'b0000);
    endtask

    task automatic t_nopar();
        par_en = 1'b0;
        // data 0x0F, stop directly after D7; then idle high
        send(8'h0F, 1'b0, 1'b1);
        chk("R7 data", rx_data, 8'h0F);
        flags("R7 no parity flag", 4'b1000);
        pulse_rd();
    endtask

    task automatic t_glitch();
        drive_bit(1'b0, 3 * TICK_DIV);
        drive_bit(1'b1, 3 * BITCLK);
        flags("R2 glitch ignored", 4'b0000);
        chk("R2 data unchanged", rx_data, 8'h0F);
        send(8'h69, 1'b0, 1'b1);
        chk("R2 next frame", rx_data, 8'h69);
        flags("R2 next flags", 4'b1000);
        pulse_rd();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (BITCLK) @(negedge clk);
        t_clean();
        t_back_to_back();
        t_overrun();
        t_parity();
        t_framing();
        t_nopar();
        t_glitch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule